// File: doc/BRIEF.md
# Interrupt-Triggered DMA Channel Controller

This block is a small DMA engine in which each of eight channels is started by an ordinary interrupt source rather than by a dedicated request line. Every channel holds a trigger selector naming one interrupt source, a source address, a destination address, a unit count, a unit size and a burst flag. Per-source request flags are kept inside the block. When a flag is raised for a source that an armed channel names, the channel claims that event, clears the flag, reads one unit of 1, 2 or 4 bytes from its source address and writes it to its destination address over a simple memory port.

After every unit, the addresses advance and the count drops by one. When the count reaches zero, the channel pulses its own end-of-transfer interrupt and clears its selector, which disarms it. Flags of sources that no armed channel claims are forwarded unchanged to the general interrupt logic. Service waits while the CPU mask level is 7 or the CPU is in standby. DMA work is therefore treated as priority level 6, whatever level the source itself has.

Top module: `irq_dma_ctrl`

## Requirements
- R1: A channel is armed only while its trigger selector is nonzero. A selector of 0 binds no source, so a request on source 0 is never serviced by DMA and is forwarded on `gen_irq[0]`.
- R2: When a channel's request is accepted, the request flag of its bound source is cleared. After a single-unit transfer disarms the channel, that source does not appear on `gen_irq` unless it fires again.
- R3: No request is accepted while `cpu_mask` equals 7. The request stays pending and is serviced once `cpu_mask` drops to 6 or below.
- R4: No request is accepted while `cpu_standby` is high. The request stays pending and is serviced after standby ends.
- R5: A unit is one read at the source address followed by one write at the destination address. The write data equals the read data. `mem_size` carries the channel's size code on both beats: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes.
- R6: After each unit, both addresses advance by the unit's byte count and the count drops by 1. If the count is still nonzero, the channel stays armed and needs a new trigger for the next unit.
- R7: When the count reaches zero, `tc_irq[c]` pulses for one cycle, in the cycle right after the final write beat, and the channel's selector is cleared to 0.
- R8: A flagged source that no armed channel names appears on `gen_irq`. This includes a source that fires after its channel has disarmed. A bit of `gen_ack` clears the matching flag.
- R9: When several channels are pending at once, the lowest-numbered channel is serviced first, one unit per grant.
- R10: With burst mode on, one trigger runs all remaining units back to back until the count reaches zero. Burst mode is bit 2 of the mode field; the size code is bits 1:0 of the same field.
- R11: While `mem_ready` is low, `mem_req`, `mem_we` and `mem_addr` hold steady until the beat completes.
- R12: Configuration writes select a field with `cfg_sel`: 0 is the selector, 1 the source address, 2 the destination address, 3 the count and 4 the mode field. The write applies to channel `cfg_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel addressed by the write |
| cfg_sel | input | 3 | Field select for the write |
| cfg_wdata | input | 16 | Configuration write data |
| irq_set | input | 16 | One-cycle interrupt event per source |
| gen_ack | input | 16 | Clears forwarded request flags |
| cpu_mask | input | 3 | CPU interrupt mask level |
| cpu_standby | input | 1 | CPU in standby; DMA held |
| gen_irq | output | 16 | Flags forwarded to general handling |
| tc_irq | output | 8 | End-of-transfer pulse per channel |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 16 | Byte address of the beat |
| mem_size | output | 2 | Unit size code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Beat completes this cycle |

## Verification
The hardest situation to reach from the ports is two channels pending in the same cycle, because a lone trigger is taken within one cycle of arriving. The bench first raises `cpu_mask` to 7, then fires both sources so that both wait together, and lowers the mask only after that. The order of the first write addresses then shows which channel was granted. The same hold-then-release approach checks R3 and R4. A stretch of low `mem_ready` keeps a read beat parked so that the bench can observe how it is held.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } dma_st_e;

    localparam logic [2:0] CF_VEC  = 3'd0;
    localparam logic [2:0] CF_SRC  = 3'd1;
    localparam logic [2:0] CF_DST  = 3'd2;
    localparam logic [2:0] CF_CNT  = 3'd3;
    localparam logic [2:0] CF_MODE = 3'd4;

    function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    unit_bytes = 3'd1;
            2'd1:    unit_bytes = 3'd2;
            default: unit_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/irq_dma_flags.sv
module irq_dma_flags #(
    parameter int NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set,
    input  logic [NSRC-1:0] clr,
    input  logic [NSRC-1:0] ack,
    input  logic [NSRC-1:0] armed,
    output logic [NSRC-1:0] flag,
    output logic [NSRC-1:0] fwd
);

    typedef struct packed {
        logic [NSRC-1:0] pend;
    } flg_t;

    flg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pend = (st_q.pend & ~clr & ~ack) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.pend;
    assign fwd  = st_q.pend & ~armed;

    // R2: a claimed flag is gone at the next edge unless a new event arrived
    p_flag_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~set)) |=> ((st_q.pend & $past(clr & ~set)) == '0));

endmodule

// File: rtl/irq_dma_prio.sv
module irq_dma_prio #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [IW-1:0] gnt_idx,
    output logic          gnt_vld
);

    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_vld = 1'b1;
                gnt_idx = IW'(i);
            end
        end
    end

    // R9: nothing below the granted index is requesting
    p_lowest_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> (req[gnt_idx] &&
                     ((req & ((N'(1) << gnt_idx) - N'(1))) == '0)));

endmodule

// File: rtl/irq_dma_chan.sv
module irq_dma_chan
    import irq_dma_pkg::*;
#(
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int SW  = 4,
    parameter int CFW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [2:0]     cfg_sel,
    input  logic [CFW-1:0] cfg_wdata,
    input  logic           upd,
    output logic [SW-1:0]  vec,
    output logic [AW-1:0]  src,
    output logic [AW-1:0]  dst,
    output logic [CW-1:0]  cnt,
    output logic [1:0]     size,
    output logic           burst,
    output logic           tc
);

    typedef struct packed {
        logic [SW-1:0] vec;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [1:0]    size;
        logic          burst;
        logic          tc;
    } ch_t;

    ch_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.tc = 1'b0;
        if (upd) begin
            st_d.src = st_q.src + AW'(unit_bytes(st_q.size));
            st_d.dst = st_q.dst + AW'(unit_bytes(st_q.size));
            st_d.cnt = st_q.cnt - CW'(1);
            if (st_q.cnt == CW'(1)) begin
                st_d.vec = '0;
                st_d.tc  = 1'b1;
            end
        end
        if (cfg_we) begin
            case (cfg_sel)
                CF_VEC:  st_d.vec = cfg_wdata[SW-1:0];
                CF_SRC:  st_d.src = cfg_wdata[AW-1:0];
                CF_DST:  st_d.dst = cfg_wdata[AW-1:0];
                CF_CNT:  st_d.cnt = cfg_wdata[CW-1:0];
                CF_MODE: begin
                    st_d.size  = cfg_wdata[1:0];
                    st_d.burst = cfg_wdata[2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec   = st_q.vec;
    assign src   = st_q.src;
    assign dst   = st_q.dst;
    assign cnt   = st_q.cnt;
    assign size  = st_q.size;
    assign burst = st_q.burst;
    assign tc    = st_q.tc;

    // R7: the end pulse comes with a disarmed selector
    p_disarm_on_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tc && !$past(cfg_we)) |-> (st_q.vec == '0));

    // R6: every unit takes exactly one off the count
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !cfg_we) |=> (st_q.cnt == $past(st_q.cnt) - CW'(1)));

endmodule

// File: rtl/irq_dma_ctrl.sv
module irq_dma_ctrl
    import irq_dma_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int NSRC = 16,
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int CW   = 16,
    localparam int CHW = $clog2(NCH),
    localparam int SW  = $clog2(NSRC),
    localparam int CFW = (AW > CW) ? AW : CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CHW-1:0]  cfg_ch,
    input  logic [2:0]      cfg_sel,
    input  logic [CFW-1:0]  cfg_wdata,
    input  logic [NSRC-1:0] irq_set,
    input  logic [NSRC-1:0] gen_ack,
    input  logic [2:0]      cpu_mask,
    input  logic            cpu_standby,
    output logic [NSRC-1:0] gen_irq,
    output logic [NCH-1:0]  tc_irq,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [1:0]      mem_size,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ready
);

    typedef struct packed {
        dma_st_e        st;
        logic [CHW-1:0] ch;
        logic [DW-1:0]  data;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [SW-1:0]   vec_a   [NCH];
    logic [AW-1:0]   src_a   [NCH];
    logic [AW-1:0]   dst_a   [NCH];
    logic [CW-1:0]   cnt_a   [NCH];
    logic [1:0]      size_a  [NCH];
    logic            burst_a [NCH];
    logic [NCH-1:0]  tc_v, upd_v, req_v;
    logic [NSRC-1:0] flag_v, armed_v, clr_v;
    logic [CHW-1:0]  gnt_idx;
    logic            gnt_vld;
    logic            may_accept;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        irq_dma_chan #(
            .AW(AW), .CW(CW), .SW(SW), .CFW(CFW)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we && (cfg_ch == CHW'(c))),
            .cfg_sel   (cfg_sel),
            .cfg_wdata (cfg_wdata),
            .upd       (upd_v[c]),
            .vec       (vec_a[c]),
            .src       (src_a[c]),
            .dst       (dst_a[c]),
            .cnt       (cnt_a[c]),
            .size      (size_a[c]),
            .burst     (burst_a[c]),
            .tc        (tc_v[c])
        );
    end

    always_comb begin
        armed_v = '0;
        req_v   = '0;
        for (int c = 0; c < NCH; c++) begin
            if (vec_a[c] != '0) begin
                armed_v[vec_a[c]] = 1'b1;
                req_v[c]          = flag_v[vec_a[c]];
            end
        end
    end

    irq_dma_flags #(.NSRC(NSRC)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .clr   (clr_v),
        .ack   (gen_ack),
        .armed (armed_v),
        .flag  (flag_v),
        .fwd   (gen_irq)
    );

    irq_dma_prio #(.N(NCH)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_v),
        .gnt_idx (gnt_idx),
        .gnt_vld (gnt_vld)
    );

    // DMA acts at level 6: blocked only by mask 7 or standby
    assign may_accept = (cpu_mask != 3'd7) && !cpu_standby;

    always_comb begin
        st_d  = st_q;
        clr_v = '0;
        upd_v = '0;
        case (st_q.st)
            ST_IDLE: begin
                if (gnt_vld && may_accept) begin
                    st_d.st                = ST_RD;
                    st_d.ch                = gnt_idx;
                    clr_v[vec_a[gnt_idx]]  = 1'b1;
                end
            end
            ST_RD: begin
                if (mem_ready) begin
                    st_d.data = mem_rdata;
                    st_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ready) begin
                    upd_v[st_q.ch] = 1'b1;
                    if (burst_a[st_q.ch] && (cnt_a[st_q.ch] != CW'(1)))
                        st_d.st = ST_RD;
                    else
                        st_d.st = ST_IDLE;
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: ST_IDLE, ch: '0, data: '0};
        else        st_q <= st_d;
    end

    assign mem_req   = (st_q.st != ST_IDLE);
    assign mem_we    = (st_q.st == ST_WR);
    assign mem_addr  = (st_q.st == ST_RD) ? src_a[st_q.ch] : dst_a[st_q.ch];
    assign mem_size  = size_a[st_q.ch];
    assign mem_wdata = st_q.data;
    assign tc_irq    = tc_v;

    // R11: a stalled beat keeps its address and direction
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3: mask level 7 keeps the engine idle
    p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && cpu_mask == 3'd7) |=> !mem_req);

    // R4: standby keeps the engine idle
    p_standby_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && cpu_standby) |=> !mem_req);

    // R7: at most one end pulse, and only right after a write beat
    p_tc_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc_irq));
    p_tc_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_irq != '0) |-> $past(mem_req && mem_we && mem_ready));

endmodule

// File: tb/irq_dma_ctrl_tb.sv
module irq_dma_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_ch = '0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] irq_set = '0;
    logic [15:0] gen_ack = '0;
    logic [2:0]  cpu_mask = '0;
    logic        cpu_standby = 1'b0;
    logic [15:0] gen_irq;
    logic [7:0]  tc_irq;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;

    always #5 clk = ~clk;

    assign mem_rdata = {~mem_addr, mem_addr};

    irq_dma_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .irq_set(irq_set),
        .gen_ack(gen_ack), .cpu_mask(cpu_mask), .cpu_standby(cpu_standby),
        .gen_irq(gen_irq), .tc_irq(tc_irq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int total = 0, bad = 0;
    int cyc = 0, wr_cnt = 0, wr_cyc = 0, tc_cyc = 0, tc_tot = 0;
    logic [15:0] first_waddr, last_waddr;
    logic [31:0] last_wdata;
    logic [1:0]  last_wsize;
    logic        finished = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n && mem_req && mem_we && mem_ready) begin
            if (wr_cnt == 0) first_waddr = mem_addr;
            wr_cnt++;
            last_waddr = mem_addr;
            last_wdata = mem_wdata;
            last_wsize = mem_size;
            wr_cyc     = cyc;
        end
        if (rst_n && tc_irq != '0) begin
            tc_tot++;
            tc_cyc = cyc;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        wr_cnt = 0; tc_tot = 0; wr_cyc = 0; tc_cyc = 0;
    endtask

    task automatic cfg(input int ch, input int sel, input int data);
        cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 3'(sel); cfg_wdata = 16'(data);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic prog(input int ch, input int src, input int sa, input int da,
                        input int cnt, input int sz, input int bu);
        cfg(ch, 1, sa);
        cfg(ch, 2, da);
        cfg(ch, 3, cnt);
        cfg(ch, 4, (bu << 2) | sz);
        cfg(ch, 0, src);
    endtask

    task automatic fire(input int src);
        irq_set = 16'(1) << src;
        @(posedge clk); #1;
        irq_set = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic ack_all();
        gen_ack = '1;
        @(posedge clk); #1;
        gen_ack = '0;
    endtask

    typedef struct packed {
        logic [2:0]  ch;
        logic [3:0]  src;
        logic [15:0] sa;
        logic [15:0] da;
        logic [7:0]  cnt;
        logic [1:0]  sz;
        logic        bu;
        logic [3:0]  trig;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{3'd0, 4'd3,  16'h1000, 16'h2000, 8'd3, 2'd2, 1'b0, 4'd2},
        '{3'd2, 4'd5,  16'h0100, 16'h0800, 8'd2, 2'd1, 1'b0, 4'd2},
        '{3'd7, 4'd15, 16'h0010, 16'h0020, 8'd1, 2'd0, 1'b0, 4'd2},
        '{3'd4, 4'd9,  16'h4000, 16'h5000, 8'd4, 2'd2, 1'b1, 4'd1},
        '{3'd1, 4'd1,  16'hFFF0, 16'h0000, 8'd1, 2'd3, 1'b0, 4'd1},
        '{3'd6, 4'd12, 16'h0200, 16'h0300, 8'd5, 2'd1, 1'b1, 4'd1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // reset state
        chk("reset mem_req", mem_req, 0);
        chk("reset tc_irq", tc_irq, 0);
        chk("reset gen_irq", gen_irq, 0);

        // table walk: R5 R6 R7 R10 R2 R8
        for (int e = 0; e < 6; e++) begin
            int nw, step;
            logic [15:0] la, ls;
            logic [31:0] ed;
            clr_mon();
            prog(TBL[e].ch, TBL[e].src, TBL[e].sa, TBL[e].da,
                 TBL[e].cnt, TBL[e].sz, TBL[e].bu);
            for (int t = 0; t < TBL[e].trig; t++) begin
                fire(TBL[e].src);
                idle(6);
            end
            idle(TBL[e].cnt * 5 + 4);
            nw   = TBL[e].bu ? int'(TBL[e].cnt)
                 : ((TBL[e].trig < TBL[e].cnt) ? int'(TBL[e].trig) : int'(TBL[e].cnt));
            step = (TBL[e].sz == 0) ? 1 : (TBL[e].sz == 1) ? 2 : 4;
            la   = 16'(TBL[e].da + (nw - 1) * step);
            ls   = 16'(TBL[e].sa + (nw - 1) * step);
            ed   = {~ls, ls};
            chk($sformatf("R6/R10 entry%0d unit count", e), wr_cnt, nw);
            chk($sformatf("R6 entry%0d last dst", e), last_waddr, la);
            chk($sformatf("R5 entry%0d data", e), last_wdata, ed);
            chk($sformatf("R5 entry%0d size code", e), last_wsize, TBL[e].sz);
            chk($sformatf("R7 entry%0d end pulses", e), tc_tot,
                (nw == int'(TBL[e].cnt)) ? 1 : 0);
            if (nw == int'(TBL[e].cnt))
                chk($sformatf("R7 entry%0d pulse timing", e), tc_cyc - wr_cyc, 1);
            chk($sformatf("R2/R8 entry%0d forwarded", e), gen_irq[TBL[e].src],
                (!TBL[e].bu && TBL[e].trig > TBL[e].cnt) ? 1 : 0);
            ack_all();
            cfg(TBL[e].ch, 0, 0);
        end

        // R3: mask 7 holds a request, mask 6 lets it through
        clr_mon();
        cpu_mask = 3'd7;
        prog(0, 2, 16'h0A00, 16'h0B00, 1, 0, 0);
        fire(2);
        idle(10);
        chk("R3 held at mask 7", wr_cnt, 0);
        chk("R8 bound source not forwarded", gen_irq[2], 0);
        cpu_mask = 3'd6;
        idle(8);
        chk("R3 served at mask 6", wr_cnt, 1);

        // R4: standby holds, release serves
        clr_mon();
        cpu_standby = 1'b1;
        prog(3, 8, 16'h0C00, 16'h0D00, 1, 2, 0);
        fire(8);
        idle(10);
        chk("R4 held in standby", wr_cnt, 0);
        cpu_standby = 1'b0;
        idle(8);
        chk("R4 served after standby", wr_cnt, 1);
        chk("R7 selector cleared", gen_irq[8], 0);
        fire(8);
        idle(3);
        chk("R8 forwarded after disarm", gen_irq[8], 1);
        chk("R7 no unit after disarm", wr_cnt, 1);
        ack_all();
        chk("R8 ack clears flag", gen_irq[8], 0);

        // R9: two channels pending together
        clr_mon();
        cpu_mask = 3'd7;
        prog(3, 6, 16'h0E00, 16'h3300, 1, 0, 0);
        prog(1, 7, 16'h0F00, 16'h1100, 1, 0, 0);
        fire(6);
        fire(7);
        idle(2);
        cpu_mask = 3'd0;
        idle(15);
        chk("R9 lowest channel first", first_waddr, 16'h1100);
        chk("R9 both served", wr_cnt, 2);

        // R1: selector 0 binds nothing
        clr_mon();
        prog(5, 0, 16'h0600, 16'h0700, 1, 0, 0);
        fire(0);
        idle(8);
        chk("R1 source 0 forwarded", gen_irq[0], 1);
        chk("R1 no DMA for selector 0", wr_cnt, 0);
        ack_all();

        // R11: stalled read beat is held
        clr_mon();
        mem_ready = 1'b0;
        prog(5, 4, 16'h1230, 16'h4560, 1, 1, 0);
        fire(4);
        idle(6);
        chk("R11 request held", mem_req, 1);
        chk("R11 read address held", mem_addr, 16'h1230);
        chk("R11 no write while stalled", wr_cnt, 0);
        mem_ready = 1'b1;
        idle(6);
        chk("R11 write after stall", last_wdata, {~16'h1230, 16'h1230});
        chk("R12 destination field", last_waddr, 16'h4560);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule